// File: doc/BRIEF.md
# Register-Window Cartridge Bank Mapper

This block is the banking logic of a cartridge for an 8-bit console. The CPU programs it through a 16-byte register window near the top of the low address space. From those registers it forms the banked program ROM address for every CPU fetch in the upper 32 KB, and the banked pattern ROM address for every PPU pattern fetch. It also drives a single nametable mirroring select. A 256-byte work RAM sits on its own 256-byte page. That RAM answers only while a key register holds one exact value.

Register writes take effect on the clock edge on which `cpu_wr` is sampled high. Both ROM address outputs, the mirroring select and the RAM read data are combinational in the current bus address, so a new bank is visible on the cycle after its write. The block has no streaming traffic, so every pin is a plain level-sampled control or data pin. There is no valid/ready handshake and no back-pressure: a strobe is accepted on every clock edge at which it is high.

Top module: `bank_mapper`

## Requirements
- R1: After reset, all program and pattern bank registers are 0, `mirror_horiz` is 0 (vertical), and the key register holds 0xFF, so the work RAM reads as 0xFF.
- R2: A write to 0x7EFA or 0x7EFB sets the 8 KB bank for CPU 0x8000-0x9FFF. A write to 0x7EFC or 0x7EFD sets the bank for 0xA000-0xBFFF. A write to 0x7EFE or 0x7EFF sets the bank for 0xC000-0xDFFF. `prg_addr` = {bank, cpu_addr[12:0]}.
- R3: For CPU 0xE000-0xFFFF the bank is the last bank (all ones), whatever the registers hold.
- R4: Writes to 0x7EF0 and 0x7EF1 set the 2 KB pattern banks for PPU 0x0000-0x07FF and 0x0800-0x0FFF. The bank used is (value >> 1) & 0x3F, and `chr_addr` = {0, bank[5:0], ppu_addr[10:0]}.
- R5: Writes to 0x7EF2, 0x7EF3, 0x7EF4 and 0x7EF5 set the 1 KB pattern banks for PPU 0x1000, 0x1400, 0x1800 and 0x1C00 in that order. `chr_addr` = {value, ppu_addr[9:0]}.
- R6: A write to 0x7EF6 stores data bit 0 on `mirror_horiz` (1 = horizontal, 0 = vertical). The other data bits have no effect.
- R7: A write to 0x7EF8 stores the key byte. The RAM is accessible only while the key equals 0xA3; any other value, including 0xA2, disables it.
- R8: The RAM occupies CPU 0x7F00-0x7FFF and is indexed by cpu_addr[7:0]. While it is disabled, reads return 0xFF and writes leave its contents unchanged.
- R9: `cpu_rdata_oe` is high only for a read (`cpu_rd`) in 0x7F00-0x7FFF. It stays low for reads of the register window and of any other address.
- R10: Writes to 0x7EF7, to 0x7EF9, or to any address outside 0x7EF0-0x7EFF change no bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one write per high cycle |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | Work RAM read data (0xFF when disabled) |
| cpu_rdata_oe | output | 1 | High when the block drives the CPU data bus |
| prg_addr | output | 21 | Program ROM address |
| ppu_addr | input | 13 | PPU pattern address |
| chr_addr | output | 18 | Pattern ROM address |
| mirror_horiz | output | 1 | Nametable mirroring select, 1 = horizontal |

## Verification
The hardest behaviour to reach is a RAM write ignored while the RAM is disabled. A disabled RAM reads as 0xFF, so the lost write cannot be seen until the key is restored. The stimulus first stores a known byte with the key open. It then writes a near-miss key, 0xA2, and writes a different byte to the same cell. Finally it reopens the key and expects the first byte back. Aliased and unused register offsets are covered the same way: each write is followed by a readback of the program address.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam logic [11:0] WIN_PAGE  = 12'h7EF;
  localparam logic [7:0]  RAM_PAGE  = 8'h7F;
  localparam logic [7:0]  KEY_RESET = 8'hFF;
  localparam logic [3:0]  OFS_MIRR  = 4'h6;
  localparam logic [3:0]  OFS_KEY   = 4'h8;
  localparam int          CHR_SLOTS = 6;
  localparam int          PRG_SLOTS = 3;
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
#(
  parameter int          PRG_BANK_W = 8,
  parameter int          CHR_BANK_W = 8,
  parameter logic [7:0]  RAM_KEY    = 8'hA3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [15:0]                            cpu_addr,
  input  logic [7:0]                             cpu_wdata,
  input  logic                                   cpu_wr,
  output logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0]   prg_q,
  output logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0]   chr_q,
  output logic                                   mirror_q,
  output logic                                   ram_on
);
  logic       win_wr;
  logic [3:0] ofs;
  logic [7:0] key_q;

  assign win_wr = cpu_wr && (cpu_addr[15:4] == WIN_PAGE);
  assign ofs    = cpu_addr[3:0];
  assign ram_on = (key_q == RAM_KEY);

  // Pattern bank slots at offsets 0..5
  for (genvar c = 0; c < CHR_SLOTS; c++) begin : g_chr
    always_ff @(posedge clk) begin
      if (!rst_n)
        chr_q[c] <= '0;
      else if (win_wr && ofs == 4'(c))
        chr_q[c] <= cpu_wdata[CHR_BANK_W-1:0];
    end
  end

  // Program bank slots: offset pairs A/B, C/D, E/F alias onto one slot
  for (genvar p = 0; p < PRG_SLOTS; p++) begin : g_prg
    always_ff @(posedge clk) begin
      if (!rst_n)
        prg_q[p] <= '0;
      else if (win_wr && ofs[3] && ofs[2:1] == 2'(p + 1))
        prg_q[p] <= cpu_wdata[PRG_BANK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mirror_q <= 1'b0;
      key_q    <= KEY_RESET;
    end else if (win_wr) begin
      if (ofs == OFS_MIRR) mirror_q <= cpu_wdata[0];
      if (ofs == OFS_KEY)  key_q    <= cpu_wdata;
    end
  end

  p_prg_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h7EFB) |=> prg_q[0] == $past(cpu_wdata[PRG_BANK_W-1:0]));

  p_mirror_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h7EF6) |=> mirror_q == $past(cpu_wdata[0]));

  p_key_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h7EF8 && cpu_wdata == RAM_KEY) |=> ram_on);

  p_hold_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !win_wr |=> ($stable(prg_q) && $stable(chr_q) && $stable(mirror_q) && $stable(ram_on)));
endmodule

// File: rtl/prg_map.sv
module prg_map
  import mapper_pkg::*;
#(
  parameter int PRG_BANK_W = 8,
  localparam int PRG_AW = PRG_BANK_W + 13
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [14:0]                          cpu_addr,
  input  logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_q,
  output logic [PRG_AW-1:0]                    prg_addr
);
  logic [PRG_BANK_W-1:0] bank;

  always_comb begin
    unique case (cpu_addr[14:13])
      2'd0:    bank = prg_q[0];
      2'd1:    bank = prg_q[1];
      2'd2:    bank = prg_q[2];
      default: bank = '1;
    endcase
  end

  assign prg_addr = {bank, cpu_addr[12:0]};

  p_fixed_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[14:13] == 2'b11) |-> (&prg_addr[PRG_AW-1:13]));
endmodule

// File: rtl/chr_map.sv
module chr_map
  import mapper_pkg::*;
#(
  parameter int CHR_BANK_W = 8,
  localparam int CHR_AW = CHR_BANK_W + 10
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [12:0]                          ppu_addr,
  input  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_q,
  output logic [CHR_AW-1:0]                    chr_addr
);
  logic [CHR_BANK_W-1:0] big_reg;
  logic [CHR_BANK_W-1:0] small_reg;

  assign big_reg   = ppu_addr[11] ? chr_q[1] : chr_q[0];
  assign small_reg = chr_q[2 + 32'(ppu_addr[11:10])];

  always_comb begin
    if (!ppu_addr[12])
      chr_addr = {1'b0, big_reg[CHR_BANK_W-2:1], ppu_addr[10:0]};
    else
      chr_addr = {small_reg, ppu_addr[9:0]};
  end

  p_small_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ppu_addr[12] |-> chr_addr[9:0] == ppu_addr[9:0]);

  p_big_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ppu_addr[12] |-> !chr_addr[CHR_AW-1]);
endmodule

// File: rtl/save_ram.sv
module save_ram #(
  parameter int RAM_AW = 8,
  localparam int DEPTH = 1 << RAM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAM_AW-1:0] idx,
  input  logic              page_hit,
  input  logic              ram_on,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_rdata_oe
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cpu_wr && page_hit && ram_on)
      mem[idx] <= cpu_wdata;
  end

  assign cpu_rdata    = ram_on ? mem[idx] : 8'hFF;
  assign cpu_rdata_oe = cpu_rd && page_hit;

  p_closed_reads_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdata_oe && !ram_on) |-> cpu_rdata == 8'hFF);

  p_oe_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |-> !cpu_rdata_oe);
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import mapper_pkg::*;
#(
  parameter int         PRG_BANK_W = 8,
  parameter int         CHR_BANK_W = 8,
  parameter logic [7:0] RAM_KEY    = 8'hA3,
  localparam int        PRG_AW     = PRG_BANK_W + 13,
  localparam int        CHR_AW     = CHR_BANK_W + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic [PRG_AW-1:0] prg_addr,
  input  logic [12:0]       ppu_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              mirror_horiz
);
  logic [PRG_SLOTS-1:0][PRG_BANK_W-1:0] prg_q;
  logic [CHR_SLOTS-1:0][CHR_BANK_W-1:0] chr_q;
  logic                                 ram_on;
  logic                                 page_hit;

  assign page_hit = (cpu_addr[15:8] == RAM_PAGE);

  mapper_regs #(.PRG_BANK_W(PRG_BANK_W), .CHR_BANK_W(CHR_BANK_W), .RAM_KEY(RAM_KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
    .prg_q(prg_q), .chr_q(chr_q), .mirror_q(mirror_horiz), .ram_on(ram_on)
  );

  prg_map #(.PRG_BANK_W(PRG_BANK_W)) u_prg (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr[14:0]), .prg_q(prg_q), .prg_addr(prg_addr)
  );

  chr_map #(.CHR_BANK_W(CHR_BANK_W)) u_chr (
    .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .chr_q(chr_q), .chr_addr(chr_addr)
  );

  save_ram #(.RAM_AW(8)) u_ram (
    .clk(clk), .rst_n(rst_n), .idx(cpu_addr[7:0]), .page_hit(page_hit), .ram_on(ram_on),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe)
  );
endmodule

// File: tb/bank_mapper_tb_top.sv
module bank_mapper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        cpu_rdata_oe;
  logic [20:0] prg_addr;
  logic [12:0] ppu_addr = '0;
  logic [17:0] chr_addr;
  logic        mirror_horiz;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
    .prg_addr(prg_addr), .ppu_addr(ppu_addr), .chr_addr(chr_addr), .mirror_horiz(mirror_horiz)
  );

  // Monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        0: act = 32'(prg_addr);
        1: act = 32'(chr_addr);
        2: act = 32'(mirror_horiz);
        3: act = 32'(cpu_rdata);
        default: act = 32'(cpu_rdata_oe);
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  // Driver: sets up the bus, pushes the expected value, waits for the monitor
  task automatic expect_out(input int sel, input logic [15:0] a, input logic [12:0] pa,
                            input logic [31:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
    cpu_addr = a;
    ppu_addr = pa;
    cpu_rd = (sel >= 3);
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
    cpu_rd = 1'b0;
  endtask

  function automatic logic [31:0] prg_exp(input logic [7:0] b, input logic [15:0] a);
    return 32'({b, a[12:0]});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_out(0, 16'h8123, 0, prg_exp(8'h00, 16'h8123), "R1 prg after reset");
    expect_out(1, 0, 13'h1400, 32'h0, "R1 chr after reset");
    expect_out(2, 0, 0, 32'h0, "R1 mirror after reset");
    expect_out(3, 16'h7F10, 0, 32'hFF, "R1 ram closed after reset");

    // R2 program banks with aliases
    cpu_write(16'h7EFA, 8'h11);
    cpu_write(16'h7EFD, 8'h22);
    cpu_write(16'h7EFE, 8'h33);
    expect_out(0, 16'h8ABC, 0, prg_exp(8'h11, 16'h8ABC), "R2 slot 8000");
    expect_out(0, 16'hA005, 0, prg_exp(8'h22, 16'hA005), "R2 slot A000 via alias");
    expect_out(0, 16'hDFFF, 0, prg_exp(8'h33, 16'hDFFF), "R2 slot C000");
    cpu_write(16'h7EFB, 8'h44);
    expect_out(0, 16'h8000, 0, prg_exp(8'h44, 16'h8000), "R2 alias 7EFB");

    // R3 fixed last bank
    expect_out(0, 16'hE000, 0, prg_exp(8'hFF, 16'hE000), "R3 E000");
    expect_out(0, 16'hFFFF, 0, prg_exp(8'hFF, 16'hFFFF), "R3 FFFF");

    // R4 2 KB pattern banks
    cpu_write(16'h7EF0, 8'hAB);
    cpu_write(16'h7EF1, 8'h7F);
    expect_out(1, 0, 13'h07FF, (32'h15 << 11) | 32'h7FF, "R4 low 2K bank");
    expect_out(1, 0, 13'h0C00, (32'h3F << 11) | 32'h400, "R4 high 2K bank");
    cpu_write(16'h7EF1, 8'h80);
    expect_out(1, 0, 13'h0801, 32'h001, "R4 bit7 dropped");

    // R5 1 KB pattern banks
    cpu_write(16'h7EF2, 8'h10);
    cpu_write(16'h7EF3, 8'h21);
    cpu_write(16'h7EF4, 8'h32);
    cpu_write(16'h7EF5, 8'hC3);
    expect_out(1, 0, 13'h1003, (32'h10 << 10) | 32'h3, "R5 slot 1000");
    expect_out(1, 0, 13'h1400, (32'h21 << 10), "R5 slot 1400");
    expect_out(1, 0, 13'h1BFF, (32'h32 << 10) | 32'h3FF, "R5 slot 1800");
    expect_out(1, 0, 13'h1C05, (32'hC3 << 10) | 32'h5, "R5 slot 1C00");

    // R6 mirroring
    cpu_write(16'h7EF6, 8'h03);
    expect_out(2, 0, 0, 32'h1, "R6 horizontal");
    cpu_write(16'h7EF6, 8'hFE);
    expect_out(2, 0, 0, 32'h0, "R6 vertical, upper bits ignored");

    // R7 / R8 key gating and ignored writes
    cpu_write(16'h7EF8, 8'hA3);
    cpu_write(16'h7F20, 8'h11);
    cpu_write(16'h7FFF, 8'hC3);
    expect_out(3, 16'h7F20, 0, 32'h11, "R8 read back open");
    expect_out(3, 16'h7FFF, 0, 32'hC3, "R8 top cell");
    cpu_write(16'h7EF8, 8'hA2);
    expect_out(3, 16'h7F20, 0, 32'hFF, "R7 near-miss key closes");
    cpu_write(16'h7F20, 8'h99);
    expect_out(3, 16'h7F20, 0, 32'hFF, "R8 closed read FF");
    cpu_write(16'h7EF8, 8'hA3);
    expect_out(3, 16'h7F20, 0, 32'h11, "R8 closed write ignored");

    // R9 output enable
    expect_out(4, 16'h7F00, 0, 32'h1, "R9 oe ram page");
    expect_out(4, 16'h7EF0, 0, 32'h0, "R9 no oe register window");
    expect_out(4, 16'h8000, 0, 32'h0, "R9 no oe rom");

    // R10 unused offsets and outside addresses
    cpu_write(16'h7EF7, 8'h55);
    cpu_write(16'h7EF9, 8'h55);
    cpu_write(16'h7DFA, 8'h99);
    cpu_write(16'h9EFA, 8'h99);
    expect_out(0, 16'h8000, 0, prg_exp(8'h44, 16'h8000), "R10 prg unchanged");
    expect_out(1, 0, 13'h1003, (32'h10 << 10) | 32'h3, "R10 chr unchanged");
    expect_out(2, 0, 0, 32'h0, "R10 mirror unchanged");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule